// File: doc/BRIEF.md
# UART Power-Down and RX Wake Sequencer

This block controls a UART's line-level behaviour while the chip is in its low-power state. A one-cycle power-down request stops the serial engines. An abort pulse goes to the transmitter and another to the receiver, but each is sent only if that engine was busy. For as long as the block stays powered down, it holds the transmit line at its idle-high level. The block resets no configuration or data register of its own, so everything outside it keeps its contents.

The block can wake the system, but only when it is armed. It is armed when four enables are all set: wake, UART, receiver and receiver interrupt. When armed, a falling edge on the receive pin raises a wake pulse. The pin is passed through a two-flop synchroniser first. After the wake, the block enters a settling window of a fixed number of cycles, 1024 by default. For the whole window, the receive path is told to discard incoming data. When the window closes, normal operation resumes. A wake interrupt pulse is raised at that moment, but only if the global and UART interrupt enables are both set. A new power-down request during the window sends the block straight back to power-down, and no interrupt is raised.

Top module: `uart_pd_wake_seq`

## Requirements
- R1: After reset, `ready_o`=1 and `tx_force_o`, `rx_discard_o`, `wake_o`, `irq_o`, `tx_abort_o` and `rx_abort_o` are all 0.
- R2: A `pd_req_i` pulse while `ready_o`=1 gives `tx_force_o`=1 and `ready_o`=0 in the next cycle. `tx_force_o` then stays 1 until a wake.
- R3: On entry to power-down, `tx_abort_o` is high for exactly one cycle if and only if `tx_busy_i` was high when the request was taken.
- R4: On entry to power-down, `rx_abort_o` is high for exactly one cycle if and only if `rx_busy_i` was high when the request was taken.
- R5: In power-down, a falling edge on `rx_i` causes a wake only when `wake_en_i`, `uart_en_i`, `rx_en_i` and `rx_irq_en_i` are all 1. Otherwise the block stays powered down and `wake_o` stays 0.
- R6: `rx_i` passes through two flops before edge detection. If `rx_i` is first sampled low at clock edge k, `wake_o` is high for one cycle after edge k+2, and `rx_discard_o` rises at the same time.
- R7: After a wake, `rx_discard_o` stays high for exactly SETTLE_CYCLES cycles. `ready_o` then returns to 1. Falling edges on `rx_i` during the window have no effect.
- R8: `irq_o` pulses for one cycle, in the first cycle with `ready_o`=1 after the window, if and only if `glob_irq_en_i` and `uart_irq_en_i` are both 1 in the last window cycle.
- R9: A `pd_req_i` pulse during the settling window returns the block to power-down in the next cycle, and no `irq_o` follows.
- R10: `pd_req_i` during power-down, and falling edges on `rx_i` while running, change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pd_req_i | input | 1 | Power-down request strobe |
| rx_i | input | 1 | Asynchronous receive pin |
| wake_en_i | input | 1 | RX wake enable |
| uart_en_i | input | 1 | UART enable |
| rx_en_i | input | 1 | Receiver enable |
| rx_irq_en_i | input | 1 | Receiver interrupt enable |
| glob_irq_en_i | input | 1 | Global interrupt enable |
| uart_irq_en_i | input | 1 | UART interrupt enable |
| tx_busy_i | input | 1 | Transmitter has a frame in flight |
| rx_busy_i | input | 1 | Receiver has a frame in flight |
| ready_o | output | 1 | Normal operation |
| tx_force_o | output | 1 | Hold TX line high (powered down) |
| rx_discard_o | output | 1 | Discard received data (settling) |
| wake_o | output | 1 | Wake pulse to the system |
| irq_o | output | 1 | Wake interrupt pulse |
| tx_abort_o | output | 1 | Abort the transmission in progress |
| rx_abort_o | output | 1 | Abort the reception in progress |

## Verification
Several properties are checked on every cycle:
- The three mode outputs are mutually exclusive.
- A wake always follows a powered-down cycle with all four arming enables set.
- The transmit override is released only by a wake.
- The interrupt appears only straight after a complete window with both interrupt enables set.
- The window length is checked by a counter.

Other behaviour needs the bench's scenarios: the synchroniser latency, abort pulses that depend on the busy inputs, aborted windows, and inputs that must be ignored. The bench sweeps every combination of arming enables, busy inputs and interrupt enables.

// File: rtl/uart_pd_pkg.sv
package uart_pd_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_PDOWN  = 2'd1,
    ST_SETTLE = 2'd2
  } pd_state_e;
endpackage

// File: rtl/uart_pd_rx_sync.sv
module uart_pd_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q[0] <= 1'b1;
    else         sync_q[0] <= rx_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[g] <= 1'b1;
      else         sync_q[g] <= sync_q[g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= sync_q[STAGES-1];
  end

  assign fall_o = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/uart_pd_settle_cnt.sv
module uart_pd_settle_cnt #(
  parameter int SETTLE_CYCLES = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic done_o
);
  localparam int CW = (SETTLE_CYCLES > 2) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (en_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = en_i && (cnt_q == LAST);
endmodule

// File: rtl/uart_pd_fsm.sv
module uart_pd_fsm
  import uart_pd_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      pd_req_i,
  input  logic      armed_i,
  input  logic      rx_fall_i,
  input  logic      settle_done_i,
  input  logic      irq_ok_i,
  input  logic      tx_busy_i,
  input  logic      rx_busy_i,
  output pd_state_e state_o,
  output logic      cnt_clr_o,
  output logic      wake_o,
  output logic      irq_o,
  output logic      tx_abort_o,
  output logic      rx_abort_o
);
  pd_state_e state_q, state_d;
  logic      wake_q, irq_q, tx_abort_q, rx_abort_q;
  logic      enter_pd, enter_settle, leave_settle;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:    if (pd_req_i) state_d = ST_PDOWN;
      ST_PDOWN:  if (armed_i && rx_fall_i) state_d = ST_SETTLE;
      ST_SETTLE: begin
        if (pd_req_i)           state_d = ST_PDOWN;
        else if (settle_done_i) state_d = ST_RUN;
      end
      default:   state_d = ST_RUN;
    endcase
  end

  assign enter_pd     = (state_d == ST_PDOWN) && (state_q != ST_PDOWN);
  assign enter_settle = (state_q == ST_PDOWN) && (state_d == ST_SETTLE);
  assign leave_settle = (state_q == ST_SETTLE) && (state_d == ST_RUN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_RUN;
      wake_q     <= 1'b0;
      irq_q      <= 1'b0;
      tx_abort_q <= 1'b0;
      rx_abort_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      wake_q     <= enter_settle;
      irq_q      <= leave_settle && irq_ok_i;
      tx_abort_q <= enter_pd && tx_busy_i;
      rx_abort_q <= enter_pd && rx_busy_i;
    end
  end

  assign state_o    = state_q;
  assign cnt_clr_o  = enter_settle;
  assign wake_o     = wake_q;
  assign irq_o      = irq_q;
  assign tx_abort_o = tx_abort_q;
  assign rx_abort_o = rx_abort_q;
endmodule

// File: rtl/uart_pd_wake_seq.sv
module uart_pd_wake_seq
  import uart_pd_pkg::*;
#(
  parameter int SETTLE_CYCLES = 1024,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pd_req_i,
  input  logic rx_i,
  input  logic wake_en_i,
  input  logic uart_en_i,
  input  logic rx_en_i,
  input  logic rx_irq_en_i,
  input  logic glob_irq_en_i,
  input  logic uart_irq_en_i,
  input  logic tx_busy_i,
  input  logic rx_busy_i,
  output logic ready_o,
  output logic tx_force_o,
  output logic rx_discard_o,
  output logic wake_o,
  output logic irq_o,
  output logic tx_abort_o,
  output logic rx_abort_o
);
  pd_state_e state;
  logic      rx_fall, settle_done, cnt_clr, armed, irq_ok;

  assign armed  = wake_en_i & uart_en_i & rx_en_i & rx_irq_en_i;
  assign irq_ok = glob_irq_en_i & uart_irq_en_i;

  uart_pd_rx_sync #(.STAGES(SYNC_STAGES)) i_rx_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rx_i   (rx_i),
    .fall_o (rx_fall)
  );

  uart_pd_settle_cnt #(.SETTLE_CYCLES(SETTLE_CYCLES)) i_settle_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .en_i   (state == ST_SETTLE),
    .done_o (settle_done)
  );

  uart_pd_fsm i_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .pd_req_i      (pd_req_i),
    .armed_i       (armed),
    .rx_fall_i     (rx_fall),
    .settle_done_i (settle_done),
    .irq_ok_i      (irq_ok),
    .tx_busy_i     (tx_busy_i),
    .rx_busy_i     (rx_busy_i),
    .state_o       (state),
    .cnt_clr_o     (cnt_clr),
    .wake_o        (wake_o),
    .irq_o         (irq_o),
    .tx_abort_o    (tx_abort_o),
    .rx_abort_o    (rx_abort_o)
  );

  assign ready_o      = (state == ST_RUN);
  assign tx_force_o   = (state == ST_PDOWN);
  assign rx_discard_o = (state == ST_SETTLE);
endmodule

// File: rtl/uart_pd_wake_seq_chk.sv
module uart_pd_wake_seq_chk #(
  parameter int SETTLE_CYCLES = 1024
) (
  input logic clk_i,
  input logic rst_ni,
  input logic wake_en_i,
  input logic uart_en_i,
  input logic rx_en_i,
  input logic rx_irq_en_i,
  input logic glob_irq_en_i,
  input logic uart_irq_en_i,
  input logic ready_o,
  input logic tx_force_o,
  input logic rx_discard_o,
  input logic wake_o,
  input logic irq_o,
  input logic tx_abort_o,
  input logic rx_abort_o
);
  localparam int LW = $clog2(SETTLE_CYCLES + 2) + 1;
  logic [LW-1:0] win_len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           win_len_q <= '0;
    else if (rx_discard_o) win_len_q <= win_len_q + 1'b1;
    else                   win_len_q <= '0;
  end

  p_one_mode_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({ready_o, tx_force_o, rx_discard_o}) == 1);

  p_pd_exit_by_wake_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(tx_force_o) && !rx_abort_o) |-> wake_o || !ready_o);

  p_tx_abort_in_pd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_abort_o |-> tx_force_o && !$past(tx_force_o));

  p_rx_abort_in_pd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_abort_o |-> tx_force_o && !$past(tx_force_o));

  p_wake_armed_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> $past(tx_force_o && wake_en_i && uart_en_i && rx_en_i && rx_irq_en_i));

  p_wake_opens_window_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> rx_discard_o);

  p_window_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_len_q <= LW'(SETTLE_CYCLES));

  p_window_full_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(rx_discard_o) && ready_o) |-> win_len_q == LW'(SETTLE_CYCLES));

  p_irq_enables_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ready_o && $past(rx_discard_o && glob_irq_en_i && uart_irq_en_i));

  p_no_irq_on_pd_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_force_o |-> !irq_o);
endmodule

bind uart_pd_wake_seq uart_pd_wake_seq_chk #(.SETTLE_CYCLES(SETTLE_CYCLES)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wake_en_i     (wake_en_i),
  .uart_en_i     (uart_en_i),
  .rx_en_i       (rx_en_i),
  .rx_irq_en_i   (rx_irq_en_i),
  .glob_irq_en_i (glob_irq_en_i),
  .uart_irq_en_i (uart_irq_en_i),
  .ready_o       (ready_o),
  .tx_force_o    (tx_force_o),
  .rx_discard_o  (rx_discard_o),
  .wake_o        (wake_o),
  .irq_o         (irq_o),
  .tx_abort_o    (tx_abort_o),
  .rx_abort_o    (rx_abort_o)
);

// File: tb/test_uart_pd_wake_seq.sv
module test_uart_pd_wake_seq;
  localparam int N = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pd_req = 1'b0, rx = 1'b1;
  logic wake_en = 1'b0, uart_en = 1'b0, rx_en = 1'b0, rx_irq_en = 1'b0;
  logic glob_irq_en = 1'b0, uart_irq_en = 1'b0, tx_busy = 1'b0, rx_busy = 1'b0;
  logic ready, tx_force, rx_discard, wake, irq, tx_abort, rx_abort;

  int total = 0, fails = 0;
  int irq_seen = 0;

  always #4 clk = ~clk;

  uart_pd_wake_seq #(.SETTLE_CYCLES(N)) i_uart_pd_wake_seq (
    .clk_i(clk), .rst_ni(rst_n), .pd_req_i(pd_req), .rx_i(rx),
    .wake_en_i(wake_en), .uart_en_i(uart_en), .rx_en_i(rx_en), .rx_irq_en_i(rx_irq_en),
    .glob_irq_en_i(glob_irq_en), .uart_irq_en_i(uart_irq_en),
    .tx_busy_i(tx_busy), .rx_busy_i(rx_busy),
    .ready_o(ready), .tx_force_o(tx_force), .rx_discard_o(rx_discard),
    .wake_o(wake), .irq_o(irq), .tx_abort_o(tx_abort), .rx_abort_o(rx_abort)
  );

  always @(negedge clk) if (rst_n && irq) irq_seen++;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_arm(input logic [3:0] m);
    {wake_en, uart_en, rx_en, rx_irq_en} = m;
  endtask

  task automatic enter_pd(input logic tb, input logic rb);
    pd_req = 1'b1; tx_busy = tb; rx_busy = rb;
    step(1);
    pd_req = 1'b0; tx_busy = 1'b0; rx_busy = 1'b0;
  endtask

  // drives rx low and returns at the sample right after the wake edge
  task automatic wake_edge(input logic exp_wake);
    rx = 1'b0;
    step(2);
    chk("R6 no wake before sync", {31'd0, wake}, 32'd0);
    step(1);
    chk("R5/R6 wake pulse", {31'd0, wake}, {31'd0, exp_wake});
    rx = 1'b1;
  endtask

  task automatic run_window(input logic exp_irq);
    int start_irq;
    logic ok;
    start_irq = irq_seen;
    ok = rx_discard;
    for (int i = 1; i < N; i++) begin
      if (i == 200) rx = 1'b0;
      if (i == 210) rx = 1'b1;
      step(1);
      if (!rx_discard || ready || irq) ok = 1'b0;
    end
    chk("R7 window held for full length", {31'd0, ok}, 32'd1);
    step(1);
    chk("R7 ready after window", {31'd0, ready}, 32'd1);
    chk("R8 irq pulse", {31'd0, irq}, {31'd0, exp_irq});
    step(1);
    chk("R8 irq one cycle", {31'd0, irq}, 32'd0);
    chk("R8 irq count", irq_seen - start_irq, {31'd0, exp_irq});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    step(2);
    chk("R1 ready", {31'd0, ready}, 32'd1);
    chk("R1 outputs idle", {25'd0, tx_force, rx_discard, wake, irq, tx_abort, rx_abort, 1'b0}, 32'd0);
    rst_n = 1'b1;
    step(2);
    chk("R1 ready after release", {31'd0, ready}, 32'd1);

    // R10: rx falls while running
    rx = 1'b0; step(6); rx = 1'b1; step(4);
    chk("R10 rx edge in run", {29'd0, ready, wake, tx_force}, 32'd4);

    // R2 R3 R4: every busy combination
    for (int b = 0; b < 4; b++) begin
      set_arm(4'hF);
      glob_irq_en = 1'b1; uart_irq_en = 1'b1;
      enter_pd(b[1], b[0]);
      chk("R2 tx forced", {30'd0, tx_force, ready}, 32'd2);
      chk("R3 tx abort", {31'd0, tx_abort}, {31'd0, b[1]});
      chk("R4 rx abort", {31'd0, rx_abort}, {31'd0, b[0]});
      step(1);
      chk("R3/R4 aborts one cycle", {30'd0, tx_abort, rx_abort}, 32'd0);
      // R10: request while powered down
      enter_pd(1'b1, 1'b1);
      step(1);
      chk("R10 pd req ignored in pd", {29'd0, tx_force, tx_abort, rx_abort}, 32'd4);
      step(20);
      chk("R2 tx force held", {31'd0, tx_force}, 32'd1);
      wake_edge(1'b1);
      run_window(1'b1);
    end

    // R5: all arming combinations
    for (int m = 0; m < 16; m++) begin
      set_arm(m[3:0]);
      enter_pd(1'b0, 1'b0);
      wake_edge(m == 15);
      step(3);
      chk("R5 state after edge", {30'd0, tx_force, rx_discard}, (m == 15) ? 32'd1 : 32'd2);
      if (m == 15) begin
        step(N - 4);
        step(3);
        chk("R5 resumed", {31'd0, ready}, 32'd1);
      end else begin
        set_arm(4'hF);
        wake_edge(1'b1);
        run_window(1'b1);
      end
    end

    // R8: interrupt enable sweep
    for (int e = 0; e < 4; e++) begin
      set_arm(4'hF);
      enter_pd(1'b0, 1'b0);
      {glob_irq_en, uart_irq_en} = e[1:0];
      wake_edge(1'b1);
      run_window(e == 3);
    end

    // R9: request during window
    glob_irq_en = 1'b1; uart_irq_en = 1'b1;
    enter_pd(1'b0, 1'b1);
    wake_edge(1'b1);
    step(100);
    begin
      int s;
      s = irq_seen;
      enter_pd(1'b0, 1'b1);
      chk("R9 back to pd", {30'd0, tx_force, rx_discard}, 32'd2);
      chk("R9 rx abort on reentry", {31'd0, rx_abort}, 32'd1);
      step(N + 50);
      chk("R9 stays in pd", {31'd0, tx_force}, 32'd1);
      chk("R9 no irq", irq_seen - s, 32'd0);
    end
    wake_edge(1'b1);
    run_window(1'b1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule